// File: doc/BRIEF.md
# Direction-Switched Card Data FIFO with Status Word

This block is the byte buffer between a host bus and a memory-card data path. One storage array of `DEPTH` bytes (64 by default) serves either direction. When `dir_tx` is high the array is a transmit buffer: the bus side pushes bytes and the card side pops them. When `dir_tx` is low it is a receive buffer: the card side pushes and the bus side pops. Both read-data outputs show the byte at the head of the queue, so the byte is visible before it is popped.

Every clock the block registers a read-only status word. The word holds the occupancy count, empty, full and two half-level flags, a transmit-space flag and a receive-data flag that depend on the direction, and a sticky flag for the last byte of a transfer. The space and data flags also drive a DMA request when DMA is enabled. A start pulse loads the total byte length of a transfer. The block counts the bytes the card pushes in receive mode and raises the last-byte flag when the count reaches that length. A flush input empties the buffer.

Top module: `card_data_fifo`

## Requirements
- R1: The occupancy count in `status[6:0]` runs from 0 to 64. It rises by one on an accepted push, falls by one on an accepted pop, and does not change when a push and a pop are both accepted in the same cycle. `status` is a register: after each rising edge it shows the state that edge produced.
- R2: With `dir_tx`=1, `bus_wr` pushes `bus_wdata` and `card_rd` pops. With `dir_tx`=0, `card_wr` pushes `card_wdata` and `bus_rd` pops. The other two strobes have no effect. Bytes leave in the order they entered. `bus_rdata` and `card_rdata` both show the head byte.
- R3: A push into a full buffer is ignored unless a pop is accepted in the same cycle. A pop from an empty buffer is ignored even if a push arrives in the same cycle. An ignored operation does not change the count.
- R4: `status[13]` (transmit space) is 1 exactly when `dir_tx`=1 and the count is 0 to 63.
- R5: `status[12]` (receive data) is 1 exactly when `dir_tx`=0 and the count is 1 to 64.
- R6: `dma_req` equals `dma_en` AND (`status[13]` OR `status[12]`).
- R7: `status[11]` is 1 when the count is 32 or less.
- R8: `status[10]` is 1 exactly when the count is 0. `status[8]` is 1 exactly when the count is 64.
- R9: `status[7]` is 1 when the count is 32 or more.
- R10: In receive mode, `status[9]` becomes 1 on the edge that accepts the card push whose running byte count equals the loaded length. The running count starts at the last start pulse, and a push in the same cycle as `start` is not counted. Once set, the flag stays 1 until the next start. A length of 0 never sets it.
- R11: A `start` pulse loads `xfer_len`, clears the running byte count and clears `status[9]` on the same edge.
- R12: `flush` sets the count to 0 on the next edge. Push and pop strobes in the same cycle are ignored. `flush` does not change `status[9]`.
- R13: While `rst_n` is low, `status` and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_tx | input | 1 | 1 = transmit buffer, 0 = receive buffer |
| dma_en | input | 1 | Enables the DMA request output |
| flush | input | 1 | Empties the buffer |
| start | input | 1 | Start of transfer: loads the length and clears the last-byte tracking |
| xfer_len | input | LEN_W (16) | Total byte count of the transfer |
| bus_wr | input | 1 | Bus-side push strobe (transmit mode) |
| bus_wdata | input | DW (8) | Bus-side push data |
| bus_rd | input | 1 | Bus-side pop strobe (receive mode) |
| bus_rdata | output | DW (8) | Head byte as seen by the bus side |
| card_wr | input | 1 | Card-side push strobe (receive mode) |
| card_wdata | input | DW (8) | Card-side push data |
| card_rd | input | 1 | Card-side pop strobe (transmit mode) |
| card_rdata | output | DW (8) | Head byte as seen by the card side |
| status | output | CNT_W+7 (14) | Registered status word |
| dma_req | output | 1 | DMA request |

## Verification
The assertions take for granted that the control inputs are synchronous to `clk` and carry known values from the first edge after reset. They also take for granted that `start` is a single-cycle pulse when the flag is expected to clear. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It changes `dir_tx` only while no strobe is active and sends `start` only when no card push is pending. This keeps the last-byte count and the status timing in the simple cases that the expected values model.

// File: rtl/cdf_pkg.sv
package cdf_pkg;

   // Width needed to hold a count from 0 to depth inclusive.
   function automatic int cnt_width(input int depth);
      return $clog2(depth + 1);
   endfunction

   // Flag positions above the count field, as offsets from CNT_W.
   localparam int OFS_RX_HALF  = 0;
   localparam int OFS_FULL     = 1;
   localparam int OFS_LAST     = 2;
   localparam int OFS_EMPTY    = 3;
   localparam int OFS_TX_HALF  = 4;
   localparam int OFS_RX_AVAIL = 5;
   localparam int OFS_TX_AVAIL = 6;
   localparam int NUM_FLAGS    = 7;

   typedef enum logic {
      DIR_RX = 1'b0,
      DIR_TX = 1'b1
   } cdf_dir_e;

endpackage

// File: rtl/cdf_store.sv
module cdf_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic             pop,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   output logic             push_ok,
   output logic             pop_ok,
   output logic [CNT_W-1:0] count_nxt
);

   localparam int  AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit  POW2     = ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
   localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);

   logic [DW-1:0]    mem [DEPTH];
   logic [AW-1:0]    wp, rp, wp_inc, rp_inc;
   logic [CNT_W-1:0] cnt_q;
   logic             is_full, is_empty;

   assign is_full  = (cnt_q == CNT_MAX);
   assign is_empty = (cnt_q == '0);
   assign push_ok  = push & (~is_full | pop) & ~flush;
   assign pop_ok   = pop & ~is_empty & ~flush;

   generate
      if (POW2) begin : g_wrap_nat
         assign wp_inc = wp + 1'b1;
         assign rp_inc = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_inc = (wp == PTR_LAST) ? '0 : wp + 1'b1;
         assign rp_inc = (rp == PTR_LAST) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_comb begin
      if (flush) begin
         count_nxt = '0;
      end else begin
         case ({push_ok, pop_ok})
            2'b10:   count_nxt = cnt_q + 1'b1;
            2'b01:   count_nxt = cnt_q - 1'b1;
            default: count_nxt = cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp <= wp_inc;
         if (pop_ok)  rp <= rp_inc;
         cnt_q <= count_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wp] <= wdata;
   end

   assign rdata = mem[rp];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX); // R1
   AST_BOTH_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok && pop_ok) |=> $stable(cnt_q)); // R1
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (is_full && push && !pop && !flush) |=> (cnt_q == CNT_MAX)); // R3
   AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (is_empty && pop && !push && !flush) |=> (cnt_q == '0)); // R3
   AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt_q == '0)); // R12

endmodule

// File: rtl/cdf_lastdet.sv
module cdf_lastdet #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   input  logic             rx_push,
   output logic             last_nxt,
   output logic             last_q
);

   logic [LEN_W-1:0] len_q, bcnt_q, bcnt_inc;
   logic             hit;

   assign bcnt_inc = bcnt_q + 1'b1;
   assign hit      = rx_push && (len_q != '0) && (bcnt_inc == len_q);

   always_comb begin
      if (start)       last_nxt = 1'b0;
      else if (last_q) last_nxt = 1'b1;
      else             last_nxt = hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q  <= '0;
         bcnt_q <= '0;
         last_q <= 1'b0;
      end else begin
         last_q <= last_nxt;
         if (start) begin
            len_q  <= len;
            bcnt_q <= '0;
         end else if (rx_push && (bcnt_q != '1)) begin
            bcnt_q <= bcnt_inc;
         end
      end
   end

   AST_LAST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (last_q && !start) |=> last_q); // R10
   AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !last_q); // R11

endmodule

// File: rtl/cdf_status.sv
module cdf_status
   import cdf_pkg::*;
#(
   parameter int DEPTH       = 64,
   parameter int CNT_W       = 7,
   parameter int TX_HALF_MAX = 32,
   parameter int RX_HALF_MIN = 32,
   localparam int STAT_W     = CNT_W + NUM_FLAGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_tx,
   input  logic [CNT_W-1:0]  count_nxt,
   input  logic              last_nxt,
   output logic [STAT_W-1:0] status
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] TXH     = CNT_W'(TX_HALF_MAX);
   localparam logic [CNT_W-1:0] RXH     = CNT_W'(RX_HALF_MIN);

   logic [NUM_FLAGS-1:0] flags;

   always_comb begin
      flags = '0;
      flags[OFS_RX_HALF]  = (count_nxt >= RXH);
      flags[OFS_FULL]     = (count_nxt == CNT_MAX);
      flags[OFS_LAST]     = last_nxt;
      flags[OFS_EMPTY]    = (count_nxt == '0);
      flags[OFS_TX_HALF]  = (count_nxt <= TXH);
      flags[OFS_RX_AVAIL] = (dir_tx == DIR_RX) && (count_nxt != '0);
      flags[OFS_TX_AVAIL] = (dir_tx == DIR_TX) && (count_nxt != CNT_MAX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= {flags, count_nxt};
   end

   AST_AVAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({status[CNT_W+OFS_TX_AVAIL], status[CNT_W+OFS_RX_AVAIL]})); // R4
   AST_EMPTY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[CNT_W+OFS_EMPTY] && status[CNT_W+OFS_FULL])); // R8

endmodule

// File: rtl/card_data_fifo.sv
module card_data_fifo
   import cdf_pkg::*;
#(
   parameter int DW          = 8,
   parameter int DEPTH       = 64,
   parameter int LEN_W       = 16,
   parameter int TX_HALF_MAX = DEPTH / 2,
   parameter int RX_HALF_MIN = DEPTH / 2,
   localparam int CNT_W      = cnt_width(DEPTH),
   localparam int STAT_W     = CNT_W + NUM_FLAGS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dir_tx,
   input  logic              dma_en,
   input  logic              flush,
   input  logic              start,
   input  logic [LEN_W-1:0]  xfer_len,
   input  logic              bus_wr,
   input  logic [DW-1:0]     bus_wdata,
   input  logic              bus_rd,
   output logic [DW-1:0]     bus_rdata,
   input  logic              card_wr,
   input  logic [DW-1:0]     card_wdata,
   input  logic              card_rd,
   output logic [DW-1:0]     card_rdata,
   output logic [STAT_W-1:0] status,
   output logic              dma_req
);

   generate
      if (DEPTH < 2)
         $error("DEPTH must be at least 2");
      if (DW < 1)
         $error("DW must be at least 1");
      if (LEN_W < 1)
         $error("LEN_W must be at least 1");
      if (TX_HALF_MAX < 0 || TX_HALF_MAX > DEPTH)
         $error("TX_HALF_MAX out of range");
      if (RX_HALF_MIN < 0 || RX_HALF_MIN > DEPTH)
         $error("RX_HALF_MIN out of range");
   endgenerate

   logic             push, pop, push_ok, pop_ok, last_nxt, last_q;
   logic [DW-1:0]    wdata, head;
   logic [CNT_W-1:0] count_nxt;

   always_comb begin
      if (dir_tx == DIR_TX) begin
         push  = bus_wr;
         pop   = card_rd;
         wdata = bus_wdata;
      end else begin
         push  = card_wr;
         pop   = bus_rd;
         wdata = card_wdata;
      end
   end

   cdf_store #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
      .wdata(wdata), .rdata(head), .push_ok(push_ok), .pop_ok(pop_ok),
      .count_nxt(count_nxt)
   );

   cdf_lastdet #(.LEN_W(LEN_W)) u_last (
      .clk(clk), .rst_n(rst_n), .start(start), .len(xfer_len),
      .rx_push(push_ok && (dir_tx == DIR_RX)),
      .last_nxt(last_nxt), .last_q(last_q)
   );

   cdf_status #(.DEPTH(DEPTH), .CNT_W(CNT_W), .TX_HALF_MAX(TX_HALF_MAX),
                .RX_HALF_MIN(RX_HALF_MIN)) u_stat (
      .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .count_nxt(count_nxt),
      .last_nxt(last_nxt), .status(status)
   );

   assign bus_rdata  = head;
   assign card_rdata = head;
   assign dma_req    = dma_en &
                       (status[CNT_W+OFS_TX_AVAIL] | status[CNT_W+OFS_RX_AVAIL]);

   AST_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> !dma_req); // R6
   AST_LAST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      status[CNT_W+OFS_LAST] == last_q); // R10

endmodule

// File: tb/card_data_fifo_test.sv
module card_data_fifo_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dir_tx = 1'b1, dma_en = 1'b0, flush = 1'b0, start = 1'b0;
   logic [15:0] xfer_len = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, card_wr = 1'b0, card_rd = 1'b0;
   logic [7:0]  bus_wdata = '0, card_wdata = '0;
   logic [7:0]  bus_rdata, card_rdata;
   logic [13:0] status;
   logic        dma_req;

   int total = 0, bad = 0;
   int mcnt = 0;
   bit mlast = 0;
   int head_idx = 0;
   bit done = 0;

   always #2 clk = ~clk;

   card_data_fifo uut (
      .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .dma_en(dma_en), .flush(flush),
      .start(start), .xfer_len(xfer_len), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rd(bus_rd), .bus_rdata(bus_rdata), .card_wr(card_wr),
      .card_wdata(card_wdata), .card_rd(card_rd), .card_rdata(card_rdata),
      .status(status), .dma_req(dma_req)
   );

   function automatic logic [13:0] exp_stat(int c, bit tx, bit l);
      logic [13:0] s;
      s[6:0] = 7'(c);
      s[7]   = (c >= 32);
      s[8]   = (c == 64);
      s[9]   = l;
      s[10]  = (c == 0);
      s[11]  = (c <= 32);
      s[12]  = !tx && (c >= 1);
      s[13]  = tx && (c < 64);
      return s;
   endfunction

   function automatic logic [7:0] pat(int i);
      return 8'((i * 37 + 11) & 255);
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_stat(string req);
      chk(req, 32'(status), 32'(exp_stat(mcnt, dir_tx, mlast)));
      chk({req, "/R6"}, 32'(dma_req),
          32'(dma_en && (dir_tx ? (mcnt < 64) : (mcnt >= 1))));
   endtask

   // one cycle: inputs set at the falling edge, cleared at the next falling edge
   task automatic cyc();
      @(negedge clk);
      bus_wr = 0; bus_rd = 0; card_wr = 0; card_rd = 0;
      flush = 0; start = 0;
   endtask

   task automatic push_n(int idx);
      if (dir_tx) begin bus_wr = 1; bus_wdata = pat(idx); end
      else begin card_wr = 1; card_wdata = pat(idx); end
   endtask

   task automatic do_flush();
      flush = 1; cyc(); mcnt = 0; head_idx = 0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R13 status in reset", 32'(status), 0);
      chk("R13 dma in reset", 32'(dma_req), 0);
      rst_n = 1;
      cyc();
      chk_stat("R8 idle after reset");

      // Transmit-mode fill sweep: every occupancy from 1 to 64, then overflow.
      dir_tx = 1; dma_en = 1;
      for (int i = 0; i < 65; i++) begin
         push_n(i); cyc();
         if (mcnt < 64) mcnt++;
         chk_stat(i == 64 ? "R3 push on full" : "R1 R4 R7 R8 R9 tx fill");
      end
      // Opposite-side strobes in transmit mode have no effect.
      card_wr = 1; bus_rd = 1; cyc();
      chk_stat("R2 rx strobes ignored in tx");
      // Full with push and pop: the count stays at 64.
      card_rd = 1; bus_wr = 1; bus_wdata = pat(64); cyc();
      head_idx = 1;
      chk_stat("R1 both at full");
      // Drain via card side, checking order.
      for (int i = 0; i < 65; i++) begin
         if (mcnt > 0) chk("R2 tx order", 32'(card_rdata), 32'(pat(head_idx)));
         if (mcnt > 0) chk("R2 bus view", 32'(bus_rdata), 32'(pat(head_idx)));
         card_rd = 1; cyc();
         if (mcnt > 0) begin mcnt--; head_idx++; end
         chk_stat(i == 64 ? "R3 pop on empty" : "R1 R4 R7 tx drain");
      end

      // Receive mode sweep with DMA off, then on.
      dir_tx = 0; dma_en = 0; cyc(); head_idx = 0;
      chk_stat("R5 rx empty");
      start = 1; xfer_len = 16'd200; cyc();
      for (int i = 0; i < 64; i++) begin
         push_n(i); cyc(); mcnt++;
         chk_stat("R5 R9 R8 rx fill");
         if (i == 31) dma_en = 1;
      end
      bus_wr = 1; card_rd = 1; cyc();
      chk_stat("R2 tx strobes ignored in rx");
      for (int i = 0; i < 64; i++) begin
         chk("R2 rx order", 32'(bus_rdata), 32'(pat(i)));
         bus_rd = 1; cyc(); mcnt--;
         chk_stat("R5 R6 rx drain");
      end
      // Pop on empty while pushing: the push lands, the pop is ignored.
      bus_rd = 1; push_n(7); cyc(); mcnt = 1;
      chk_stat("R3 pop on empty with push");
      chk("R2 head after", 32'(bus_rdata), 32'(pat(7)));
      // Simultaneous push and pop mid-level.
      push_n(8); cyc(); mcnt = 2;
      bus_rd = 1; push_n(9); cyc();
      chk_stat("R1 both mid level");
      chk("R2 head after both", 32'(bus_rdata), 32'(pat(8)));

      // Flush.
      do_flush();
      chk_stat("R12 flush empties");

      // Last-byte detection with length 5.
      start = 1; xfer_len = 16'd5; cyc();
      chk_stat("R11 start clears");
      for (int i = 0; i < 7; i++) begin
         push_n(i); cyc(); mcnt++;
         if (i == 4) mlast = 1;
         chk_stat("R10 last byte");
      end
      do_flush();
      chk_stat("R12 flush keeps last");
      start = 1; xfer_len = 16'd0; cyc(); mlast = 0;
      chk_stat("R11 start clears last");
      for (int i = 0; i < 3; i++) begin
         push_n(i); cyc(); mcnt++;
         chk_stat("R10 zero length never");
      end
      // Last byte after the buffer has cycled (length above the depth).
      do_flush();
      start = 1; xfer_len = 16'd70; cyc();
      for (int i = 0; i < 70; i++) begin
         push_n(i); if (mcnt > 0) bus_rd = 1;
         cyc();
         if (mcnt == 0) mcnt = 1;
         if (i == 69) mlast = 1;
         chk_stat("R10 long transfer");
      end
      // Flush ignores strobes in the same cycle.
      flush = 1; push_n(1); cyc(); mcnt = 0;
      chk_stat("R12 flush with push");
      // The transmit side does not count toward the last byte.
      start = 1; xfer_len = 16'd1; cyc(); mlast = 0;
      dir_tx = 1; cyc();
      push_n(3); cyc(); mcnt = 1;
      chk_stat("R10 tx pushes not counted");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule